// File: doc/BRIEF.md
# Registered 12-to-24-bit Bus Exchanger

This block connects one 12-bit A port to two 12-bit B ports, called B1 and B2. Going from A to B, each B port has its own capture register, and each register has its own active-low load enable. If B1's enable is lowered on one clock and B2's on the next, two A words that arrived one after the other are then presented side by side as a single 24-bit word on the B ports.

Going from B to A, a single register captures one B port on every clock. An active-low select input chooses which port it takes. The A output comes only from this register, so it changes only at a clock edge.

The select, load enables and output enables are all sampled on the clock edge. Each port's tri-state pad is modelled as a data bus plus a drive flag. The drive flag is the registered inverse of that port's active-low output-enable pin. A synchronous reset gives known register and drive values before any transfer takes place.

Top module: `bus_exchanger`

## Requirements
- R1: While the synchronous reset is sampled high at a clock edge, that edge clears aOut, b1Out and b2Out to zero and clears aDrive, b1Drive and b2Drive to 0 (not driving).
- R2: At a rising edge where loadB1N is 0, b1Out takes the aIn value sampled at that edge. Where loadB1N is 1, b1Out keeps its previous value.
- R3: At a rising edge where loadB2N is 0, b2Out takes the aIn value sampled at that edge. Where loadB2N is 1, b2Out keeps its previous value.
- R4: When loadB1N and loadB2N are both 0 at the same edge, b1Out and b2Out both receive the same aIn word.
- R5: Lowering loadB1N at one edge and loadB2N at the following edge leaves the first word on b1Out and the second on b2Out together. Read as {b2Out, b1Out}, they form a 24-bit word.
- R6: At every rising edge out of reset, aOut loads b2In if pickN is 0 and loads b1In if pickN is 1.
- R7: aOut does not change between clock edges, even when b1In, b2In or pickN change during the cycle.
- R8: After each rising edge out of reset, aDrive equals the inverse of driveAN sampled at that edge. b1Drive and b2Drive follow driveB1N and driveB2N in the same way, and each enable is independent of the others.
- R9: The output enables have no effect on capture: the B and A registers load exactly as in R2, R3 and R6 while their drive flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | 12 | Word arriving on the A side |
| b1In | input | 12 | Word arriving on the B1 side |
| b2In | input | 12 | Word arriving on the B2 side |
| loadB1N | input | 1 | Active-low capture enable for the B1 register |
| loadB2N | input | 1 | Active-low capture enable for the B2 register |
| pickN | input | 1 | Active-low select: 0 loads B2, 1 loads B1 into the A register |
| driveAN | input | 1 | Active-low output enable for the A port |
| driveB1N | input | 1 | Active-low output enable for the B1 port |
| driveB2N | input | 1 | Active-low output enable for the B2 port |
| aOut | output | 12 | A register contents |
| aDrive | output | 1 | A pad drives when 1 |
| b1Out | output | 12 | B1 register contents |
| b1Drive | output | 1 | B1 pad drives when 1 |
| b2Out | output | 12 | B2 register contents |
| b2Drive | output | 1 | B2 pad drives when 1 |

## Verification
Every result has a latency of exactly one edge: the data registers and drive flags reflect the inputs sampled at the most recent rising edge. The bench changes inputs at the falling edge and reads outputs one time unit after the next rising edge. It compares them with a model that it advances once per edge. For the stability check, the bench changes the B inputs and the select in the middle of a cycle and reads aOut again before the next edge.

// File: rtl/exch_pkg.sv
package exch_pkg;

  // Active-high strobes from control to datapath, valid for the current edge
  typedef struct packed {
    logic [1:0] bLoad;      // [0] loads B1, [1] loads B2
    logic       pickSecond; // 1: A register takes B2
  } strobe_t;

  localparam int NUM_B_LANES = 2;

endpackage

// File: rtl/exch_ctrl.sv
module exch_ctrl
  import exch_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    loadB1N,
  input  logic    loadB2N,
  input  logic    pickN,
  input  logic    driveAN,
  input  logic    driveB1N,
  input  logic    driveB2N,
  output strobe_t strobes,
  output logic    liveOut,
  output logic    aDrive,
  output logic    b1Drive,
  output logic    b2Drive
);

  localparam int NUM_OE = NUM_B_LANES + 1;

  logic [NUM_OE-1:0] oePinN;
  logic [NUM_OE-1:0] driveQ;
  logic              liveQ;

  assign oePinN = {driveB2N, driveB1N, driveAN};

  // Control pins are taken at the same edge that moves the data
  always_comb begin
    strobes.bLoad[0]   = ~loadB1N;
    strobes.bLoad[1]   = ~loadB2N;
    strobes.pickSecond = ~pickN;
  end

  // liveQ marks that the previous edge was out of reset
  always_ff @(posedge clk) begin
    liveQ <= ~rst;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_OE; gi++) begin : g_oe
      always_ff @(posedge clk) begin
        if (rst) driveQ[gi] <= 1'b0;
        else     driveQ[gi] <= ~oePinN[gi];
      end

      // R8: each drive flag follows its own pin one edge later
      a_r8_drive_follows_pin: assert property (@(posedge clk) disable iff (rst)
        liveQ |-> (driveQ[gi] == ~$past(oePinN[gi])));
    end
  endgenerate

  assign aDrive  = driveQ[0];
  assign b1Drive = driveQ[1];
  assign b2Drive = driveQ[2];
  assign liveOut = liveQ;

endmodule

// File: rtl/exch_datapath.sv
module exch_datapath
  import exch_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              live,
  input  strobe_t           strobes,
  input  logic [WORD_W-1:0] aIn,
  input  logic [WORD_W-1:0] b1In,
  input  logic [WORD_W-1:0] b2In,
  output logic [WORD_W-1:0] aOut,
  output logic [WORD_W-1:0] b1Out,
  output logic [WORD_W-1:0] b2Out
);

  logic [WORD_W-1:0] laneQ [NUM_B_LANES];
  logic [WORD_W-1:0] laneIn [NUM_B_LANES];
  logic [WORD_W-1:0] aQ;

  assign laneIn[0] = b1In;
  assign laneIn[1] = b2In;

  genvar li;
  generate
    for (li = 0; li < NUM_B_LANES; li++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst)                    laneQ[li] <= '0;
        else if (strobes.bLoad[li]) laneQ[li] <= aIn;
      end

      // R2 / R3: capture on an enabled edge
      a_r2_r3_lane_capture: assert property (@(posedge clk) disable iff (rst)
        (live && $past(strobes.bLoad[li])) |-> (laneQ[li] == $past(aIn)));

      // R2 / R3: hold on a disabled edge
      a_r2_r3_lane_hold: assert property (@(posedge clk) disable iff (rst)
        (live && !$past(strobes.bLoad[li])) |-> $stable(laneQ[li]));
    end
  endgenerate

  // B-to-A register loads on every edge from the selected lane
  always_ff @(posedge clk) begin
    if (rst)                     aQ <= '0;
    else if (strobes.pickSecond) aQ <= laneIn[1];
    else                         aQ <= laneIn[0];
  end

  // R6: A register reflects the selected B input of the previous edge
  a_r6_a_from_second: assert property (@(posedge clk) disable iff (rst)
    (live && $past(strobes.pickSecond)) |-> (aQ == $past(b2In)));
  a_r6_a_from_first: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(strobes.pickSecond)) |-> (aQ == $past(b1In)));

  assign aOut  = aQ;
  assign b1Out = laneQ[0];
  assign b2Out = laneQ[1];

endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] aIn,
  input  logic [WORD_W-1:0] b1In,
  input  logic [WORD_W-1:0] b2In,
  input  logic              loadB1N,
  input  logic              loadB2N,
  input  logic              pickN,
  input  logic              driveAN,
  input  logic              driveB1N,
  input  logic              driveB2N,
  output logic [WORD_W-1:0] aOut,
  output logic              aDrive,
  output logic [WORD_W-1:0] b1Out,
  output logic              b1Drive,
  output logic [WORD_W-1:0] b2Out,
  output logic              b2Drive
);

  exch_pkg::strobe_t strobes;
  logic              live;

  exch_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .loadB1N  (loadB1N),
    .loadB2N  (loadB2N),
    .pickN    (pickN),
    .driveAN  (driveAN),
    .driveB1N (driveB1N),
    .driveB2N (driveB2N),
    .strobes  (strobes),
    .liveOut  (live),
    .aDrive   (aDrive),
    .b1Drive  (b1Drive),
    .b2Drive  (b2Drive)
  );

  exch_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .live    (live),
    .strobes (strobes),
    .aIn     (aIn),
    .b1In    (b1In),
    .b2In    (b2In),
    .aOut    (aOut),
    .b1Out   (b1Out),
    .b2Out   (b2Out)
  );

endmodule

// File: tb/bus_exchanger_bench.sv
`timescale 1ns/1ps
module bus_exchanger_bench;

  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] aIn = '0, b1In = '0, b2In = '0;
  logic loadB1N = 1'b1, loadB2N = 1'b1, pickN = 1'b1;
  logic driveAN = 1'b1, driveB1N = 1'b1, driveB2N = 1'b1;
  logic [W-1:0] aOut, b1Out, b2Out;
  logic aDrive, b1Drive, b2Drive;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [W-1:0] mA = '0, m1 = '0, m2 = '0;
  logic eA = 1'b0, e1 = 1'b0, e2 = 1'b0;

  always #5 clk = ~clk;

  bus_exchanger u_bus_exchanger (
    .clk(clk), .rst(rst), .aIn(aIn), .b1In(b1In), .b2In(b2In),
    .loadB1N(loadB1N), .loadB2N(loadB2N), .pickN(pickN),
    .driveAN(driveAN), .driveB1N(driveB1N), .driveB2N(driveB2N),
    .aOut(aOut), .aDrive(aDrive), .b1Out(b1Out), .b1Drive(b1Drive),
    .b2Out(b2Out), .b2Drive(b2Drive)
  );

  function automatic logic [W-1:0] pickWord(input logic selN,
                                            input logic [W-1:0] w1,
                                            input logic [W-1:0] w2);
    return selN ? w1 : w2;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // advance model with inputs present at the coming edge
  task automatic modelEdge();
    if (rst) begin
      mA = '0; m1 = '0; m2 = '0; eA = 0; e1 = 0; e2 = 0;
    end else begin
      mA = pickWord(pickN, b1In, b2In);
      if (!loadB1N) m1 = aIn;
      if (!loadB2N) m2 = aIn;
      eA = ~driveAN; e1 = ~driveB1N; e2 = ~driveB2N;
    end
  endtask

  task automatic step();
    modelEdge();
    @(posedge clk);
    #1;
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " R2 b1Out"}, b1Out, m1);
    chk({tag, " R3 b2Out"}, b2Out, m2);
    chk({tag, " R6 aOut"},  aOut,  mA);
    chk({tag, " R8 aDrive"},  {{(W-1){1'b0}}, aDrive},  {{(W-1){1'b0}}, eA});
    chk({tag, " R8 b1Drive"}, {{(W-1){1'b0}}, b1Drive}, {{(W-1){1'b0}}, e1});
    chk({tag, " R8 b2Drive"}, {{(W-1){1'b0}}, b2Drive}, {{(W-1){1'b0}}, e2});
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] w1, input logic [W-1:0] w2,
                       input logic l1, input logic l2, input logic s,
                       input logic oa, input logic o1, input logic o2);
    @(negedge clk);
    aIn = a; b1In = w1; b2In = w2;
    loadB1N = l1; loadB2N = l2; pickN = s;
    driveAN = oa; driveB1N = o1; driveB2N = o2;
  endtask

  initial begin : watchdog
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stimulus
    logic [W-1:0] held;
    void'($urandom(32'd20240611));

    // R1: reset with loads and enables active must still clear everything
    drive(12'hABC, 12'h111, 12'h222, 0, 0, 0, 0, 0, 0);
    step(); step();
    checkAll("R1 reset");

    // R9: leave reset with drives off; capture still happens
    drive(12'h5A5, 12'h0F0, 12'hF0F, 0, 1, 0, 1, 1, 1);
    rst = 1'b0;
    step();
    checkAll("R9 capture while undriven");

    // R5: sequential demux of two words
    drive(12'h123, 12'h000, 12'h000, 0, 1, 1, 0, 0, 0);
    step();
    drive(12'h456, 12'h000, 12'h000, 1, 0, 1, 0, 0, 0);
    step();
    checkAll("R5 pair");
    chk("R5 24-bit word", {b2Out[11:0]}, 12'h456);
    chk("R5 24-bit word low", b1Out, 12'h123);

    // R4: both enables low in one edge
    drive(12'h9E7, 12'h000, 12'h000, 0, 0, 1, 1, 0, 1);
    step();
    checkAll("R4 both");
    chk("R4 same word", b1Out, b2Out);

    // R6 select both ways, and R7 stability inside a cycle
    drive(12'h000, 12'hAAA, 12'h555, 1, 1, 0, 0, 1, 0);
    step();
    checkAll("R6 pick B2");
    drive(12'h000, 12'hAAA, 12'h555, 1, 1, 1, 0, 1, 0);
    step();
    checkAll("R6 pick B1");
    held = aOut;
    b1In = 12'h3C3; b2In = 12'hC3C; pickN = 1'b0;
    #2;
    chk("R7 aOut stable mid-cycle", aOut, held);
    b1In = 12'hAAA; b2In = 12'h555; pickN = 1'b1;

    // Random phase: R2 R3 R6 R8 under mixed patterns
    for (int i = 0; i < 400; i++) begin
      drive(W'($urandom), W'($urandom), W'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));
      step();
      checkAll("random");
    end

    // R1: reset again after activity
    drive(12'hFFF, 12'hFFF, 12'hFFF, 0, 0, 0, 0, 0, 0);
    rst = 1'b1;
    step();
    checkAll("R1 re-reset");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule